// File: doc/BRIEF.md
# Single-wire network command stage

This block sits between a single-wire bit-slot engine and the memory command decoder of a slave device. After every bus reset it runs the network selection stage: it collects an eight-bit command, then either streams out its 64-bit identity, compares an identity sent by the master, takes part in the bitwise search arbitration, or selects itself without addressing. When the stage ends with the device selected, `selected` goes high and the memory layer takes over the bus until the next reset. If the stage ends otherwise, the device goes silent until the next reset.

The bit engine reports each finished time slot with a one-cycle `slot_valid` pulse carrying the sampled line level. Before each slot it reads `tx_active` and `tx_bit` to decide whether the slave drives a zero in that slot. A bus reset is reported with `bus_reset`. `reset_std` tells the block whether that reset pulse had standard-speed length. The block keeps two flags. The resume flag remembers the last successful addressed selection. The overdrive flag drives `od_speed`, which tells the bit engine which slot timing to use.

The identity is fixed at elaboration. Its low byte is the family code, the next 48 bits are the serial parameter, and the top byte is a CRC computed over the lower 56 bits.

Top module: `onew_rom_layer`

## Requirements
- R1: The identity has family code 2Dh in bits 7:0, the serial number in bits 55:8, and in bits 63:56 the CRC with polynomial x^8+x^5+x^4+1. The CRC shift register starts at zero and takes bit 0 first. Running the same CRC over all 64 bits gives zero.
- R2: After `rst_n` is released, slots are ignored until the first `bus_reset`. Any `bus_reset` aborts the current function, drops `selected` and `tx_active`, and waits for a new command. `bus_reset` takes priority over `slot_valid` in the same cycle.
- R3: The command byte arrives in eight slots, least significant bit first. The codes are 33h read, 55h match, F0h search, CCh skip, A5h resume, 3Ch overdrive-skip and 69h overdrive-match.
- R4: Read (33h) drives the 64 identity bits out in the next 64 slots, bit 0 first, with `tx_active` high. It then selects the device and sets the resume flag.
- R5: Match (55h) compares the next 64 received bits with the identity, bit 0 first. If all 64 are equal, the device is selected and the resume flag is set. At the first difference the device goes silent and the resume flag is cleared.
- R6: Search (F0h) uses three slots per identity bit. In the first the slave sends the bit, in the second its complement, and in the third it reads the master's choice. A choice that differs from the identity bit makes the device silent and clears the resume flag. After 64 bits the device is selected and the resume flag is set.
- R7: Skip (CCh) selects the device at once and clears the resume flag.
- R8: Resume (A5h) selects the device only when the resume flag is set, and otherwise makes it silent. The flag survives bus resets and is cleared by `rst_n`.
- R9: Overdrive-skip (3Ch) raises `od_speed` and selects the device as soon as the command byte ends. It also clears the resume flag.
- R10: Overdrive-match (69h) raises `od_speed` as soon as the command byte ends, then behaves as match. A difference also lowers `od_speed`.
- R11: A `bus_reset` with `reset_std` high lowers `od_speed`. A `bus_reset` with `reset_std` low leaves it unchanged.
- R12: An unknown command byte makes the device silent. Until the next bus reset, `tx_active` and `selected` stay low and all slots are ignored.
- R13: While selected, slots do not change any output. `tx_active` is low, and `tx_bit` reads 1 whenever `tx_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a reset pulse was seen on the line |
| reset_std | input | 1 | Qualifies `bus_reset`: the pulse had standard-speed length |
| slot_valid | input | 1 | One-cycle pulse: a time slot completed |
| slot_rx | input | 1 | Line level sampled in that slot |
| tx_active | output | 1 | The coming slot is a slave-transmit slot |
| tx_bit | output | 1 | Bit the slave sends in the coming slot (0 = pull low) |
| od_speed | output | 1 | Overdrive flag; selects the fast slot timing |
| selected | output | 1 | Network stage finished with this device addressed |

## Verification
The bound checker watches every cycle for the properties that do not depend on the identity. A bus reset always clears selection and transmission, and `reset_std` decides whether `od_speed` survives a reset. `od_speed` and `selected` can only rise at a slot boundary. Selection holds until a reset, and outputs stay stable between slots. Only the bench scenarios can show the identity-dependent behaviour: the bit order and CRC of the streamed identity, match and search failing at a chosen bit, the resume flag carried across resets, and silence after an unknown command. A behavioural model in the bench is compared against all four outputs on every clock.

// File: rtl/onew_rom_pkg.sv
// Package: shared state encodings, command codes and identity construction
// for the single-wire network command stage.
// Assumes: identity is 64 bits, command bytes are 8 bits, data LSB first.
package onew_rom_pkg;

    localparam int ID_W  = 64;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_RESUME = 8'hA5;
    localparam logic [CMD_W-1:0] OP_OD_SKP = 8'h3C;
    localparam logic [CMD_W-1:0] OP_OD_MAT = 8'h69;

    typedef enum logic [2:0] {
        ST_WAIT,    // after rst_n, before the first bus reset
        ST_CMD,     // collecting the command byte
        ST_READ,    // streaming the identity out
        ST_MATCH,   // comparing the identity in
        ST_SEARCH,  // bitwise arbitration
        ST_SEL,     // addressed, memory layer owns the bus
        ST_DROP     // silent until the next bus reset
    } net_state_t;

    typedef enum logic [1:0] {
        PH_TRUE,    // send identity bit
        PH_CMPL,    // send its complement
        PH_DIR      // read master's direction bit
    } srch_ph_t;

    // Reflected CRC-8 (x^8+x^5+x^4+1), zero start, bit 0 first.
    function automatic logic [7:0] net_crc8(input logic [ID_W-9:0] d);
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = 0; i < ID_W - 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    // Identity word: CRC on top, serial in the middle, family at the bottom.
    function automatic logic [ID_W-1:0] net_make_id(input logic [7:0]  fam,
                                                    input logic [47:0] ser);
        logic [ID_W-9:0] body;
        body = {ser, fam};
        return {net_crc8(body), body};
    endfunction

endpackage

// File: rtl/onew_rom_cmd_shift.sv
// Module: command byte collector.
// Shifts received slot bits in LSB first and flags the slot that completes
// a byte. The completed byte is offered combinationally in that same cycle.
// Assumes: clear has priority over shift_en.
module onew_rom_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         rx_bit,
    output logic [W-1:0] byte_full,
    output logic         byte_done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    // Newest bit enters at the top, so the first bit ends at bit 0.
    assign byte_full = {rx_bit, sr_q[W-1:1]};
    assign byte_done = shift_en && (cnt_q == CW'(W - 1));

    // Shift register and bit counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sr_q  <= byte_full;
            cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/onew_rom_id_ptr.sv
// Module: identity bit pointer.
// Presents the identity bit at the current index, starting from bit 0, and
// flags the last index. Read, match and search all share this pointer.
// Assumes: ID_W is a power of two, so advancing past the end wraps to zero.
module onew_rom_id_ptr #(
    parameter int              ID_W   = 64,
    parameter logic [ID_W-1:0] ID_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic id_bit,
    output logic id_last
);
    localparam int IW = $clog2(ID_W);

    logic [IW-1:0] idx_q;

    assign id_bit  = ID_VAL[idx_q];
    assign id_last = (idx_q == IW'(ID_W - 1));

    // Index register, restarted at every bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) idx_q <= '0;
        else if (advance)    idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/onew_rom_layer.sv
// Module: network (ROM) command stage of a single-wire slave.
// Decodes the command byte that follows each bus reset and runs read, match,
// search, skip, resume, overdrive-skip or overdrive-match against a fixed
// 64-bit identity. It keeps the resume and overdrive flags.
// Assumes: a bit engine pulses slot_valid once per slot, samples tx_* before
// the slot, and reports resets with bus_reset (priority over slot_valid).
module onew_rom_layer
    import onew_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h2D,
    parameter logic [47:0] SERIAL = 48'h0000_5E1A_93C7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic reset_std,
    input  logic slot_valid,
    input  logic slot_rx,
    output logic tx_active,
    output logic tx_bit,
    output logic od_speed,
    output logic selected
);
    localparam logic [ID_W-1:0] ID_VAL = net_make_id(FAMILY, SERIAL);

    net_state_t       st_q;
    srch_ph_t         ph_q;
    logic             rc_q;
    logic             od_q;
    logic             odm_q;
    logic [CMD_W-1:0] cmd_full;
    logic             cmd_done;
    logic             id_bit;
    logic             id_last;
    logic             slot_go;
    logic             ptr_adv;

    assign slot_go = slot_valid && !bus_reset;
    assign ptr_adv = slot_go && ((st_q == ST_READ) || (st_q == ST_MATCH) ||
                                 (st_q == ST_SEARCH && ph_q == PH_DIR));

    onew_rom_cmd_shift #(.W(CMD_W)) cmd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bus_reset),
        .shift_en  (slot_go && st_q == ST_CMD),
        .rx_bit    (slot_rx),
        .byte_full (cmd_full),
        .byte_done (cmd_done)
    );

    onew_rom_id_ptr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (bus_reset),
        .advance (ptr_adv),
        .id_bit  (id_bit),
        .id_last (id_last)
    );

    // Command stage state, search phase and the two flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            ph_q  <= PH_TRUE;
            rc_q  <= 1'b0;
            od_q  <= 1'b0;
            odm_q <= 1'b0;
        end else if (bus_reset) begin
            st_q  <= ST_CMD;
            ph_q  <= PH_TRUE;
            odm_q <= 1'b0;
            if (reset_std) od_q <= 1'b0;
        end else if (slot_valid) begin
            unique case (st_q)
                ST_CMD: if (cmd_done) begin
                    unique case (cmd_full)
                        OP_READ:   st_q <= ST_READ;
                        OP_MATCH:  st_q <= ST_MATCH;
                        OP_SEARCH: st_q <= ST_SEARCH;
                        OP_SKIP: begin
                            st_q <= ST_SEL;
                            rc_q <= 1'b0;
                        end
                        OP_RESUME: st_q <= rc_q ? ST_SEL : ST_DROP;
                        OP_OD_SKP: begin
                            st_q <= ST_SEL;
                            rc_q <= 1'b0;
                            od_q <= 1'b1;
                        end
                        OP_OD_MAT: begin
                            st_q  <= ST_MATCH;
                            od_q  <= 1'b1;
                            odm_q <= 1'b1;
                        end
                        default:   st_q <= ST_DROP;
                    endcase
                end
                ST_READ: if (id_last) begin
                    st_q <= ST_SEL;
                    rc_q <= 1'b1;
                end
                ST_MATCH: begin
                    if (slot_rx != id_bit) begin
                        st_q <= ST_DROP;
                        rc_q <= 1'b0;
                        if (odm_q) od_q <= 1'b0;
                    end else if (id_last) begin
                        st_q <= ST_SEL;
                        rc_q <= 1'b1;
                    end
                end
                ST_SEARCH: begin
                    unique case (ph_q)
                        PH_TRUE: ph_q <= PH_CMPL;
                        PH_CMPL: ph_q <= PH_DIR;
                        default: begin
                            ph_q <= PH_TRUE;
                            if (slot_rx != id_bit) begin
                                st_q <= ST_DROP;
                                rc_q <= 1'b0;
                            end else if (id_last) begin
                                st_q <= ST_SEL;
                                rc_q <= 1'b1;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Slave-transmit slots: the read stream and the first two search phases.
    always_comb begin
        tx_active = (st_q == ST_READ) ||
                    (st_q == ST_SEARCH && ph_q != PH_DIR);
        tx_bit    = tx_active ? (id_bit ^ (st_q == ST_SEARCH && ph_q == PH_CMPL))
                              : 1'b1;
    end

    assign od_speed = od_q;
    assign selected = (st_q == ST_SEL);
endmodule

// File: rtl/onew_rom_layer_chk.sv
// Module: protocol checker for onew_rom_layer, attached with bind.
// Observes only the ports and checks every-cycle rules on resets, speed,
// selection and output stability.
module onew_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic reset_std,
    input logic slot_valid,
    input logic slot_rx,
    input logic tx_active,
    input logic tx_bit,
    input logic od_speed,
    input logic selected
);
    // R2: a bus reset always clears selection and transmission.
    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!selected && !tx_active));

    // R11: a standard-length reset lowers the speed flag.
    assert_std_reset_slow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && reset_std) |=> !od_speed);

    // R11: a short reset leaves the speed flag alone.
    assert_od_reset_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !reset_std) |=> $stable(od_speed));

    // R9: overdrive is entered only at the end of a slot.
    assert_od_rise_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_speed) |-> ($past(slot_valid) && !$past(bus_reset)));

    // R7: selection only follows a completed slot.
    assert_sel_rise_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> ($past(slot_valid) && !$past(bus_reset)));

    // R13: once selected, only a reset deselects.
    assert_sel_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> selected);

    // R4: outputs do not move between slots.
    assert_tx_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_valid && !bus_reset) |=> ($stable(tx_active) && $stable(tx_bit)));

    // R13: the released line level is presented when not transmitting.
    assert_idle_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_bit);
endmodule

bind onew_rom_layer onew_rom_layer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .reset_std  (reset_std),
    .slot_valid (slot_valid),
    .slot_rx    (slot_rx),
    .tx_active  (tx_active),
    .tx_bit     (tx_bit),
    .od_speed   (od_speed),
    .selected   (selected)
);

// File: tb/onew_rom_layer_tb_top.sv
`timescale 1ns/1ps
module onew_rom_layer_tb_top;

    localparam logic [47:0] TB_SERIAL = 48'h0000_5E1A_93C7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0;
    logic reset_std = 1'b0;
    logic slot_valid = 1'b0;
    logic slot_rx = 1'b0;
    logic tx_active, tx_bit, od_speed, selected;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    onew_rom_layer #(.FAMILY(8'h2D), .SERIAL(TB_SERIAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_std(reset_std),
        .slot_valid(slot_valid), .slot_rx(slot_rx), .tx_active(tx_active),
        .tx_bit(tx_bit), .od_speed(od_speed), .selected(selected)
    );

    // Expected identity built from R1 in shift-register form.
    function automatic logic [63:0] exp_id();
        logic [55:0] body;
        logic [7:0]  c;
        logic        fb;
        body = {TB_SERIAL, 8'h2D};
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ body[i];
            c  = {fb, c[7:1]} ^ {4'b0, fb, fb, 2'b0};
        end
        return {c, body};
    endfunction

    function automatic logic [7:0] crc_all(input logic [63:0] v);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 0; i < 64; i++) begin
            fb = c[0] ^ v[i];
            c  = {fb, c[7:1]} ^ {4'b0, fb, fb, 2'b0};
        end
        return c;
    endfunction

    logic [63:0] ID;
    initial ID = exp_id();

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Behavioural reference: mode numbers 0 wait,1 cmd,2 read,3 match,4 search,5 sel,6 drop.
    int   m_mode = 0, m_cnt = 0, m_pos = 0, m_ph = 0;
    logic [7:0] m_cmd = 8'h00;
    bit   m_rc = 0, m_od = 0, m_odm = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_rc = 0; m_od = 0; m_odm = 0;
            m_cnt = 0; m_pos = 0; m_ph = 0;
        end else if (bus_reset) begin
            m_mode = 1; m_cnt = 0; m_pos = 0; m_ph = 0; m_odm = 0;
            if (reset_std) m_od = 0;
        end else if (slot_valid) begin
            case (m_mode)
                1: begin
                    m_cmd[m_cnt] = slot_rx;
                    m_cnt++;
                    if (m_cnt == 8) begin
                        case (m_cmd)
                            8'h33: m_mode = 2;
                            8'h55: m_mode = 3;
                            8'hF0: m_mode = 4;
                            8'hCC: begin m_mode = 5; m_rc = 0; end
                            8'hA5: m_mode = m_rc ? 5 : 6;
                            8'h3C: begin m_mode = 5; m_rc = 0; m_od = 1; end
                            8'h69: begin m_mode = 3; m_od = 1; m_odm = 1; end
                            default: m_mode = 6;
                        endcase
                    end
                end
                2: begin
                    if (m_pos == 63) begin m_mode = 5; m_rc = 1; end
                    m_pos++;
                end
                3: begin
                    if (slot_rx != ID[m_pos]) begin
                        m_mode = 6; m_rc = 0;
                        if (m_odm) m_od = 0;
                    end else if (m_pos == 63) begin m_mode = 5; m_rc = 1; end
                    m_pos++;
                end
                4: begin
                    if (m_ph < 2) m_ph++;
                    else begin
                        m_ph = 0;
                        if (slot_rx != ID[m_pos]) begin m_mode = 6; m_rc = 0; end
                        else if (m_pos == 63) begin m_mode = 5; m_rc = 1; end
                        m_pos++;
                    end
                end
                default: ;
            endcase
        end
    end

    // Lockstep comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ea, eb;
            ea = (m_mode == 2) || (m_mode == 4 && m_ph < 2);
            eb = !ea ? 1'b1 : (m_mode == 2 ? ID[m_pos % 64] :
                               (m_ph == 0 ? ID[m_pos % 64] : !ID[m_pos % 64]));
            chk("R13 model selected", 64'(selected), 64'(m_mode == 5));
            chk("R11 model od_speed", 64'(od_speed), 64'(m_od));
            chk("R4 model tx_active", 64'(tx_active), 64'(ea));
            chk("R4 model tx_bit", 64'(tx_bit), 64'(eb));
        end
    end

    task automatic slot(input logic b);
        slot_valid = 1'b1; slot_rx = b;
        @(negedge clk);
        slot_valid = 1'b0; slot_rx = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(output logic b);
        b = tx_active ? tx_bit : 1'b1;
        slot(b);
    endtask

    task automatic bres(input logic std);
        bus_reset = 1'b1; reset_std = std;
        @(negedge clk);
        bus_reset = 1'b0; reset_std = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] c);
        for (int i = 0; i < 8; i++) slot(c[i]);
    endtask

    task automatic send_id(input logic [63:0] v);
        for (int i = 0; i < 64; i++) slot(v[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state and slots ignored before first bus reset
        chk("R2 reset selected", 64'(selected), 64'd0);
        chk("R2 reset od_speed", 64'(od_speed), 64'd0);
        send(8'hCC);
        chk("R2 pre-reset slots ignored", 64'(selected), 64'd0);

        // R1 identity format
        chk("R1 family byte", 64'(ID[7:0]), 64'h2D);
        chk("R1 crc residue", 64'(crc_all(ID)), 64'd0);

        // R3/R4 read
        bres(1'b1);
        send(8'h33);
        chk("R3 read decoded", 64'(tx_active), 64'd1);
        for (int i = 0; i < 64; i++) begin rd(b); got[i] = b; end
        chk("R4 read identity", got, ID);
        chk("R4 read selects", 64'(selected), 64'd1);
        slot(1'b0); slot(1'b1);
        chk("R13 slots ignored when selected", 64'({selected, tx_active}), 64'b10);

        // R8 resume after read
        bres(1'b1); send(8'hA5);
        chk("R8 resume with flag", 64'(selected), 64'd1);

        // R2 abort mid-read
        bres(1'b1); send(8'h33);
        for (int i = 0; i < 10; i++) rd(b);
        bres(1'b1);
        chk("R2 reset aborts read", 64'(tx_active), 64'd0);
        send(8'hCC);
        chk("R7 skip selects", 64'(selected), 64'd1);
        bres(1'b1); send(8'hA5);
        chk("R7 skip clears resume flag", 64'(selected), 64'd0);

        // R5 match
        bres(1'b1); send(8'h55); send_id(ID);
        chk("R5 match selects", 64'(selected), 64'd1);
        bres(1'b1); send(8'hA5);
        chk("R5 match sets resume flag", 64'(selected), 64'd1);
        bres(1'b1); send(8'h55); send_id(ID ^ (64'd1 << 40));
        chk("R5 mismatch not selected", 64'(selected), 64'd0);
        bres(1'b1); send(8'hA5);
        chk("R5 mismatch clears resume flag", 64'(selected), 64'd0);

        // R6 search
        bres(1'b1); send(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd(a); rd(b);
            if (i == 0 || i == 63) begin
                chk("R6 search true bit", 64'(a), 64'(ID[i]));
                chk("R6 search complement", 64'(b), 64'(!ID[i]));
            end
            slot(a);
        end
        chk("R6 search selects", 64'(selected), 64'd1);
        bres(1'b1); send(8'hF0);
        for (int i = 0; i < 11; i++) begin
            rd(a); rd(b);
            slot(i == 10 ? !a : a);
        end
        rd(a);
        chk("R6 search dropout silent", 64'({tx_active, selected}), 64'd0);
        bres(1'b1); send(8'hA5);
        chk("R6 dropout clears resume flag", 64'(selected), 64'd0);

        // R12 unknown command
        bres(1'b1); send(8'h99);
        send(8'hCC);
        chk("R12 unknown goes silent", 64'({tx_active, selected}), 64'd0);

        // R9 / R11 overdrive skip
        bres(1'b1); send(8'h3C);
        chk("R9 od skip speed and select", 64'({od_speed, selected}), 64'b11);
        bres(1'b0);
        chk("R11 short reset keeps overdrive", 64'(od_speed), 64'd1);
        send(8'hA5);
        chk("R9 od skip clears resume flag", 64'(selected), 64'd0);
        bres(1'b1);
        chk("R11 std reset leaves overdrive", 64'(od_speed), 64'd0);

        // R10 overdrive match
        send(8'h69);
        chk("R10 od after command byte", 64'(od_speed), 64'd1);
        send_id(ID);
        chk("R10 od match selects", 64'({od_speed, selected}), 64'b11);
        bres(1'b1); send(8'h69); send_id(~ID);
        chk("R10 od mismatch drops speed", 64'({od_speed, selected}), 64'b00);

        // R8 resume flag cleared by rst_n
        bres(1'b1); send(8'h55); send_id(ID);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        bres(1'b1); send(8'hA5);
        chk("R8 rst_n clears resume flag", 64'(selected), 64'd0);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule